// File: doc/BRIEF.md
# Slave FIFO packet write controller

This controller lives in an FPGA and drives the synchronous write port of a USB bridge's slave FIFO. Upstream logic hands it packets as a valid/ready word stream with a last flag. The controller turns each accepted word into one write cycle on the bridge interface. The bridge has four active-low controls: chip select, write strobe, packet end and the FIFO address.

A packet shorter than the bridge's buffer is committed by asserting packet end in the same cycle as the write strobe of its final word. If packet end is given after the data, in a separate cycle without a write strobe, the bridge sends an extra empty packet to the host. The controller never produces that sequence on its own. It issues a deliberate zero-length packet only on an explicit request: one cycle with packet end and chip select low and the write strobe high.

A typical stream starts with a leader of 52 bytes, which is 13 words at the default 4-byte bus. Payload packets follow, and they use exactly the same write sequence. Every packet ends with at least one cycle in which chip select is released.

Top module: `sfifo_pkt_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it, cs_n, wr_n and pktend_n are high and s_ready is low.
- R2: s_ready is high only while a packet is open and fifo_space is high. When fifo_space is low, no word is accepted and wr_n stays high in the following cycle.
- R3: A word accepted in cycle N (s_valid and s_ready both high) appears on fifo_data in cycle N+1, with wr_n and cs_n low. wr_n is low in no other cycle.
- R4: pktend_n is low together with wr_n in the write cycle of the word that carried s_last. It is high in the write cycles of all other words.
- R5: In the cycle after any cycle with pktend_n low, cs_n and pktend_n are high. A commit is therefore never followed by a cycle with packet end alone.
- R6: zlp_req sampled high while the controller is idle produces, in the next cycle, exactly one cycle with cs_n low, pktend_n low and wr_n high. cs_n is high in the cycle after that. The request takes priority over a pending s_valid, and that packet is sent afterwards.
- R7: zlp_req while a packet is open is ignored. pktend_n never goes low while wr_n is high, except as the response of R6.
- R8: fifo_addr takes the value of addr_sel when a packet or zero-length packet starts. It does not change while cs_n stays low.
- R9: A 13-word leader and the payload packets after it each produce their words in order and exactly one packet-end cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 8*BUS_BYTES | Upstream word |
| s_valid | input | 1 | Upstream word valid |
| s_last | input | 1 | Word is the last of its packet |
| s_ready | output | 1 | Controller accepts the word this cycle |
| zlp_req | input | 1 | Request a zero-length packet (honoured in idle) |
| addr_sel | input | ADDR_W | FIFO address for the next packet |
| fifo_space | input | 1 | Bridge FIFO is not full (active high) |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| pktend_n | output | 1 | Packet end, active low |
| fifo_addr | output | ADDR_W | FIFO address, held through each packet |
| fifo_data | output | 8*BUS_BYTES | Data word to the bridge |

## Verification
All bridge-side outputs are registered. A handshake sampled at one clock edge shows up as a write cycle one cycle later. Packet end follows the same rule, and chip select is released in the cycle after that. A zero-length request seen in idle gives its packet-end cycle one cycle later, and chip select returns high one cycle after that.

The bench drives inputs on the falling edge and reads s_ready just before the rising edge. A monitor samples the outputs on each falling edge. It compares each write cycle against the handshake it recorded one falling edge earlier, and it compares the cycle after any packet-end cycle against the release rule. Packet contents, packet-end counts and zero-length counts are checked only after the interface has returned to idle.

// File: rtl/sfifo_pkt_writer.sv
module sfifo_pkt_writer #(
  parameter int BUS_BYTES = 4,
  parameter int ADDR_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*BUS_BYTES-1:0] s_data,
  input  logic                   s_valid,
  input  logic                   s_last,
  output logic                   s_ready,
  input  logic                   zlp_req,
  input  logic [ADDR_W-1:0]      addr_sel,
  input  logic                   fifo_space,
  output logic                   cs_n,
  output logic                   wr_n,
  output logic                   pktend_n,
  output logic [ADDR_W-1:0]      fifo_addr,
  output logic [8*BUS_BYTES-1:0] fifo_data
);
  localparam int DW = 8 * BUS_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_ZLP} state_t;
  state_t state;

  logic hs;
  assign s_ready = (state == S_XFER) && fifo_space;
  assign hs      = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cs_n      <= 1'b1;
      wr_n      <= 1'b1;
      pktend_n  <= 1'b1;
      fifo_addr <= '0;
      fifo_data <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          wr_n     <= 1'b1;
          pktend_n <= 1'b1;
          if (zlp_req) begin
            state     <= S_ZLP;
            cs_n      <= 1'b0;
            pktend_n  <= 1'b0;
            fifo_addr <= addr_sel;
          end else if (s_valid) begin
            state     <= S_XFER;
            cs_n      <= 1'b0;
            fifo_addr <= addr_sel;
          end else begin
            cs_n <= 1'b1;
          end
        end
        S_XFER: begin
          if (hs) begin
            wr_n      <= 1'b0;
            pktend_n  <= ~s_last;
            fifo_data <= s_data;
            if (s_last) state <= S_GAP;
          end else begin
            wr_n     <= 1'b1;
            pktend_n <= 1'b1;
          end
        end
        default: begin
          cs_n     <= 1'b1;
          wr_n     <= 1'b1;
          pktend_n <= 1'b1;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  a_r2_ready_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> fifo_space);

  a_r3_write_follows_hs: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (!wr_n && !cs_n && fifo_data == $past(s_data)));

  a_r3_no_write_without_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs && state != S_IDLE) |=> wr_n);

  a_r3_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  a_r4_pktend_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && s_last) |=> (!pktend_n && !wr_n));

  a_r4_no_early_pktend: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !s_last) |=> pktend_n);

  a_r5_release_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n |=> (cs_n && pktend_n));

  a_r7_zlp_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!pktend_n && wr_n) |-> ($past(zlp_req) && !cs_n));

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(fifo_addr));

  initial begin
    a_r1_width_sane: assert (DW >= 8);
  end
endmodule

// File: tb/sfifo_pkt_writer_tb_top.sv
`timescale 1ns/1ps
module sfifo_pkt_writer_tb_top;
  localparam int BB = 4;
  localparam int AW = 2;
  localparam int DW = 8 * BB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0, zlp_req = 1'b0, fifo_space = 1'b1;
  logic [AW-1:0] addr_sel = '0;
  logic s_ready, cs_n, wr_n, pktend_n;
  logic [AW-1:0] fifo_addr;
  logic [DW-1:0] fifo_data;

  always #2 clk = ~clk;

  sfifo_pkt_writer #(.BUS_BYTES(BB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .zlp_req(zlp_req), .addr_sel(addr_sel), .fifo_space(fifo_space),
    .cs_n(cs_n), .wr_n(wr_n), .pktend_n(pktend_n), .fifo_addr(fifo_addr), .fifo_data(fifo_data));

  int compared = 0, mismatched = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] len;
    logic [1:0] addr;
    logic [7:0] stall;
    logic       zlp_mid;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{len: 8'd13, addr: 2'd0, stall: 8'h00, zlp_mid: 1'b0},
    '{len: 8'd40, addr: 2'd0, stall: 8'h24, zlp_mid: 1'b0},
    '{len: 8'd1,  addr: 2'd1, stall: 8'h00, zlp_mid: 1'b1},
    '{len: 8'd2,  addr: 2'd2, stall: 8'hF0, zlp_mid: 1'b0},
    '{len: 8'd13, addr: 2'd3, stall: 8'h55, zlp_mid: 1'b1},
    '{len: 8'd5,  addr: 2'd1, stall: 8'h81, zlp_mid: 1'b0}
  };

  logic [DW-1:0] log_d [64];
  logic [AW-1:0] log_a [64];
  logic          log_e [64];
  int nlog = 0, zlp_cnt = 0;
  logic mon_on = 1'b0;
  logic prev_hs = 1'b0, prev_pe = 1'b0, prev_cs = 1'b0;
  logic [DW-1:0] prev_d = '0;
  logic [AW-1:0] prev_a = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (s_ready && !fifo_space) chk("R2 ready without space", 1, 0);
      if (prev_hs) begin
        chk("R3 write after handshake", {wr_n, cs_n}, 2'b00);
        chk("R3 data after handshake", fifo_data, prev_d);
      end else if (!wr_n) chk("R3 write without handshake", wr_n, 1);
      if (prev_pe) chk("R5 release after commit", {cs_n, pktend_n}, 2'b11);
      if (prev_cs && !cs_n) chk("R8 address held", fifo_addr, prev_a);
      if (!wr_n && !cs_n && nlog < 64) begin
        log_d[nlog] = fifo_data; log_a[nlog] = fifo_addr; log_e[nlog] = !pktend_n;
        nlog++;
      end
      if (!pktend_n && wr_n && !cs_n) zlp_cnt++;
      prev_pe = !pktend_n;
      prev_cs = !cs_n;
      prev_a  = fifo_addr;
      #1;
      prev_hs = s_valid && s_ready;
      prev_d  = s_data;
    end
  end

  int cyc = 0;
  task automatic send_pkt(input int len, input logic [DW-1:0] base, input logic [AW-1:0] a,
                          input logic [7:0] stall, input logic zmid);
    int i = 0;
    logic h;
    addr_sel = a;
    while (i < len) begin
      @(negedge clk);
      fifo_space = ~stall[cyc % 8];
      cyc++;
      s_valid = 1'b1;
      s_data = base + DW'(i);
      s_last = (i == len - 1);
      zlp_req = zmid && (i > 0);
      #1.5;
      h = s_ready;
      @(posedge clk);
      if (h) i++;
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; zlp_req = 1'b0; fifo_space = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_pkt(input string req, input int len, input logic [DW-1:0] base,
                           input logic [AW-1:0] a);
    int ends = 0;
    chk({req, " word count"}, nlog, len);
    for (int k = 0; k < nlog && k < len; k++) begin
      chk({req, " word"}, log_d[k], base + DW'(k));
      chk("R8 packet address", log_a[k], a);
      chk("R4 pktend placement", log_e[k], k == len - 1);
      if (log_e[k]) ends++;
    end
    chk("R9 one packet end", ends, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {cs_n, wr_n, pktend_n, s_ready}, 4'b1110);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {cs_n, wr_n, pktend_n, s_ready}, 4'b1110);
    mon_on = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [DW-1:0] base;
      int z0;
      base = DW'(32'hA000_0000 + v * 256);
      nlog = 0; z0 = zlp_cnt;
      send_pkt(int'(VEC[v].len), base, VEC[v].addr, VEC[v].stall, VEC[v].zlp_mid);
      check_pkt(v == 0 ? "R9 leader" : "R9 payload", int'(VEC[v].len), base, VEC[v].addr);
      chk(VEC[v].zlp_mid ? "R7 zlp ignored mid packet" : "R7 no stray zlp", zlp_cnt, z0);
    end

    // R6: standalone zero-length packet
    nlog = 0;
    @(negedge clk); addr_sel = 2'd2; zlp_req = 1'b1;
    @(negedge clk); zlp_req = 1'b0;
    chk("R6 zlp cycle", {cs_n, wr_n, pktend_n}, 3'b010);
    chk("R6 zlp address", fifo_addr, 2'd2);
    @(negedge clk);
    chk("R6 release after zlp", {cs_n, wr_n, pktend_n}, 3'b111);
    chk("R6 one zlp", zlp_cnt, 1);
    chk("R6 no data with zlp", nlog, 0);

    // R6: zlp priority over pending word
    @(negedge clk);
    addr_sel = 2'd3; zlp_req = 1'b1; s_valid = 1'b1; s_data = 32'h5A5A_0001; s_last = 1'b1;
    @(negedge clk); zlp_req = 1'b0;
    chk("R6 zlp wins over data", {cs_n, wr_n, pktend_n}, 3'b010);
    repeat (4) @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 zlp count after priority", zlp_cnt, 2);
    chk("R6 pending word sent", nlog, 1);
    if (nlog > 0) begin
      chk("R6 pending word data", log_d[0], 32'h5A5A_0001);
      chk("R4 single word commit", log_e[0], 1);
    end

    // R2: stalled space blocks acceptance
    nlog = 0;
    @(negedge clk); fifo_space = 1'b0; addr_sel = 2'd1;
    s_valid = 1'b1; s_data = 32'h0000_BEEF; s_last = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 no write while full", nlog, 0);
    chk("R2 select held while full", cs_n, 0);
    fifo_space = 1'b1;
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 word after space returns", nlog, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule